// File: doc/BRIEF.md
# Scan-Chain Register Access Port

This block is a test-port data register through which a debug host reads and writes a bank of 32-bit registers. A minimal test access port state machine, driven by TCK and TMS, holds a 4-bit instruction register. One instruction picks a scan-chain number. A second instruction opens a 40-bit access chain. When that chain is shifted, it carries a data word, a register address and a direction bit. At Update-DR the request crosses into the system clock domain through a toggle handshake. There, a small register bank stub either stores the word or looks up the addressed register.

Results come back one scan late. A read fetches its value in the system domain and holds it. The next access scan then loads that value into its data field at Capture-DR, so the host shifts out the result while it shifts in the next request. Some reads have side effects: a read of the trace memory window steps its read pointer. A host that only wants to collect a pending result therefore addresses the identification register, which has no side effect.

The bank stub holds these registers: an identification word, a memory depth word, a scratch register, a memory data window, and separate read and write pointers for a small trace memory.

Top module: `dbg_reg_chain`

## Requirements
- R1: After reset the instruction is bypass: a DR scan goes through a 1-bit register that captures 0, and TDO is 0 outside the Shift states. An IR scan captures 4'b0001, shifted out LSB first.
- R2: The access chain is 40 bits, shifted LSB first: bits 31:0 are data, bits 38:32 are the address, and bit 39 is the direction bit (1 = write, 0 = read). The address field and the direction bit capture as 0.
- R3: An access scan with the direction bit at 1 stores its data into the addressed register at Update-DR.
- R4: The data field captured by an access scan is the result of the most recent read scan. A write scan leaves that result unchanged.
- R5: A read of address 4 (memory window) returns the entry at the read pointer and then advances the pointer. A read of address 0 (identification) returns the identification value and moves neither pointer.
- R6: A write to address 4 stores the word at the write pointer and advances that pointer. Address 5 (read pointer) and address 6 (write pointer) can be read and written. Both pointers wrap modulo the memory depth.
- R7: Address 1 reads the memory depth. Address 2 is a read/write scratch register. Writes to addresses 0, 1, 3 and 7 to 127 have no effect, and reads of address 3 and of 7 to 127 return 0.
- R8: Instruction 4'h2 selects a 4-bit chain-number register, which captures the current chain number. Instruction 4'hC takes effect only while the chain number is 0. Any other chain number makes access scans capture 0 and have no effect. The chain number resets to 4'hF.
- R9: Instruction codes other than 4'h2 and 4'hC select the 1-bit bypass register.
- R10: Five TCK cycles with TMS high reach Test-Logic-Reset, which restores the bypass instruction and chain number 4'hF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock of the register bank |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out, valid during the Shift states |

## Verification
On every cycle the assertions check several local properties. Five TMS-high cycles always land in Test-Logic-Reset. A request toggle happens only at Update-DR with the access instruction on chain 0. The control bits of the access chain capture as zero. In bypass, the first shifted bit is zero. In the system domain, a memory-window read steps the read pointer by exactly one, a read of the identification register leaves both pointers alone, and a write to an unmapped address changes nothing. Other behaviour shows only across whole scenarios run by the bench: the one-scan delay of read results, the data that ends up in the bank after writes, pointer wrap, chain-number gating and the effect of Test-Logic-Reset. The bench checks these against a scoreboard model.

// File: rtl/dbg_chain_pkg.sv
`timescale 1ns/1ps
package dbg_chain_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 7;
    localparam int CHAIN_W = DATA_W + ADDR_W + 1;
    localparam int IR_W    = 4;

    localparam logic [IR_W-1:0] OP_SELECT  = 4'h2;
    localparam logic [IR_W-1:0] OP_ACCESS  = 4'hC;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    localparam logic [ADDR_W-1:0] A_ID      = 7'd0;
    localparam logic [ADDR_W-1:0] A_DEPTH   = 7'd1;
    localparam logic [ADDR_W-1:0] A_SCRATCH = 7'd2;
    localparam logic [ADDR_W-1:0] A_RAM     = 7'd4;
    localparam logic [ADDR_W-1:0] A_RPTR    = 7'd5;
    localparam logic [ADDR_W-1:0] A_WPTR    = 7'd6;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EX1_DR, TS_PAUSE_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EX1_IR, TS_PAUSE_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_e;

    // Bit order matches the shift chain: data at the LSB end, direction at the MSB.
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } acc_req_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        case (s)
            TS_RESET:    return tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:     return tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR:   return tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR:   return tms ? TS_EX1_DR : TS_SHIFT_DR;
            TS_SHIFT_DR: return tms ? TS_EX1_DR : TS_SHIFT_DR;
            TS_EX1_DR:   return tms ? TS_UPD_DR : TS_PAUSE_DR;
            TS_PAUSE_DR: return tms ? TS_EX2_DR : TS_PAUSE_DR;
            TS_EX2_DR:   return tms ? TS_UPD_DR : TS_SHIFT_DR;
            TS_UPD_DR:   return tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR:   return tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR:   return tms ? TS_EX1_IR : TS_SHIFT_IR;
            TS_SHIFT_IR: return tms ? TS_EX1_IR : TS_SHIFT_IR;
            TS_EX1_IR:   return tms ? TS_UPD_IR : TS_PAUSE_IR;
            TS_PAUSE_IR: return tms ? TS_EX2_IR : TS_PAUSE_IR;
            TS_EX2_IR:   return tms ? TS_UPD_IR : TS_SHIFT_IR;
            default:     return tms ? TS_SEL_DR : TS_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/dbg_sync2.sv
`timescale 1ns/1ps
module dbg_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dbg_tap_fsm.sv
`timescale 1ns/1ps
module dbg_tap_fsm
    import dbg_chain_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge tck) begin
        if (rst) state <= TS_RESET;
        else     state <= tap_next(state, tms);
    end

    // Checker: count consecutive TMS-high edges, saturating at five.
    logic [2:0] hi_run;
    always_ff @(posedge tck) begin
        if (rst)               hi_run <= 3'd0;
        else if (!tms)         hi_run <= 3'd0;
        else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
    end

    p_five_tms_reset_r10: assert property (@(posedge tck) disable iff (rst)
        (hi_run == 3'd5) |-> (state == TS_RESET));
endmodule

// File: rtl/dbg_chain_tck.sv
`timescale 1ns/1ps
module dbg_chain_tck
    import dbg_chain_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic              tck,
    input  logic              rst,
    input  logic              tdi,
    input  tap_state_e        state,
    input  logic              ack_sync,
    input  logic [DATA_W-1:0] rd_data,
    output logic              tdo,
    output logic              req_tgl,
    output acc_req_t          req
);
    logic [IR_W-1:0]    ir_shift, ir;
    logic [SEL_W-1:0]   sel_shift, chain_sel;
    logic [CHAIN_W-1:0] dr_acc;
    logic [DATA_W-1:0]  rd_buf;
    logic               byp, ack_seen;
    logic               is_acc, is_sel, chain_ok, busy;

    assign is_acc   = (ir == OP_ACCESS);
    assign is_sel   = (ir == OP_SELECT);
    assign chain_ok = (chain_sel == '0);
    assign busy     = (req_tgl != ack_seen);

    always_ff @(posedge tck) begin
        if (rst) begin
            ir_shift  <= '0;
            ir        <= OP_BYPASS;
            sel_shift <= '0;
            chain_sel <= '1;
            dr_acc    <= '0;
            rd_buf    <= '0;
            byp       <= 1'b0;
            ack_seen  <= 1'b0;
            req_tgl   <= 1'b0;
            req       <= '0;
        end else begin
            if (ack_sync != ack_seen) begin
                ack_seen <= ack_sync;
                rd_buf   <= rd_data;
            end
            case (state)
                TS_RESET: begin
                    ir        <= OP_BYPASS;
                    chain_sel <= '1;
                end
                TS_CAP_IR:   ir_shift <= IR_CAPTURE;
                TS_SHIFT_IR: ir_shift <= {tdi, ir_shift[IR_W-1:1]};
                TS_UPD_IR:   ir       <= ir_shift;
                TS_CAP_DR: begin
                    if (is_acc)
                        dr_acc <= {{(CHAIN_W-DATA_W){1'b0}}, chain_ok ? rd_buf : '0};
                    else if (is_sel)
                        sel_shift <= chain_sel;
                    else
                        byp <= 1'b0;
                end
                TS_SHIFT_DR: begin
                    if (is_acc)      dr_acc    <= {tdi, dr_acc[CHAIN_W-1:1]};
                    else if (is_sel) sel_shift <= {tdi, sel_shift[SEL_W-1:1]};
                    else             byp       <= tdi;
                end
                TS_UPD_DR: begin
                    if (is_sel) begin
                        chain_sel <= sel_shift;
                    end else if (is_acc && chain_ok && !busy) begin
                        req     <= acc_req_t'(dr_acc);
                        req_tgl <= ~req_tgl;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        tdo = 1'b0;
        if (state == TS_SHIFT_IR)      tdo = ir_shift[0];
        else if (state == TS_SHIFT_DR) tdo = is_acc ? dr_acc[0] : (is_sel ? sel_shift[0] : byp);
    end

    p_req_needs_chain0_r8: assert property (@(posedge tck) disable iff (rst)
        (req_tgl != $past(req_tgl)) |->
            ($past(chain_sel) == '0 && $past(state) == TS_UPD_DR && $past(ir) == OP_ACCESS));

    p_ctl_capture_zero_r2: assert property (@(posedge tck) disable iff (rst)
        (state == TS_CAP_DR && is_acc) |=> (dr_acc[CHAIN_W-1:DATA_W] == '0));

    p_bypass_first_bit_r9: assert property (@(posedge tck) disable iff (rst)
        (state == TS_CAP_DR && !is_acc && !is_sel) |=> (tdo == 1'b0));
endmodule

// File: rtl/dbg_regfile_stub.sv
`timescale 1ns/1ps
module dbg_regfile_stub
    import dbg_chain_pkg::*;
#(
    parameter int                RAM_DEPTH = 16,
    parameter logic [DATA_W-1:0] ID_VALUE  = 32'h0B57_1D01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_sync,
    input  acc_req_t          req,
    output logic              ack_tgl,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PTR_W = $clog2(RAM_DEPTH);

    logic [DATA_W-1:0] mem [RAM_DEPTH];
    logic [DATA_W-1:0] scratch, lookup;
    logic [PTR_W-1:0]  rptr, wptr;
    logic              req_seen, do_acc;

    assign do_acc  = (req_sync != req_seen);
    assign ack_tgl = req_seen;

    always_comb begin
        case (req.addr)
            A_ID:      lookup = ID_VALUE;
            A_DEPTH:   lookup = DATA_W'(RAM_DEPTH);
            A_SCRATCH: lookup = scratch;
            A_RAM:     lookup = mem[rptr];
            A_RPTR:    lookup = DATA_W'(rptr);
            A_WPTR:    lookup = DATA_W'(wptr);
            default:   lookup = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_seen <= 1'b0;
            rd_data  <= '0;
            scratch  <= '0;
            rptr     <= '0;
            wptr     <= '0;
        end else if (do_acc) begin
            req_seen <= req_sync;
            if (req.wr) begin
                case (req.addr)
                    A_SCRATCH: scratch <= req.data;
                    A_RAM:     wptr    <= wptr + 1'b1;
                    A_RPTR:    rptr    <= req.data[PTR_W-1:0];
                    A_WPTR:    wptr    <= req.data[PTR_W-1:0];
                    default: ;
                endcase
            end else begin
                rd_data <= lookup;
                if (req.addr == A_RAM) rptr <= rptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && do_acc && req.wr && req.addr == A_RAM) mem[wptr] <= req.data;
    end

    p_ram_read_step_r5: assert property (@(posedge clk) disable iff (rst)
        (do_acc && !req.wr && req.addr == A_RAM) |=> (rptr == $past(rptr) + 1'b1));

    p_id_read_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (do_acc && req.addr == A_ID) |=> ($stable(rptr) && $stable(wptr)));

    p_unmapped_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (do_acc && req.wr && (req.addr == 7'd3 || req.addr > A_WPTR))
            |=> ($stable(scratch) && $stable(rptr) && $stable(wptr)));
endmodule

// File: rtl/dbg_reg_chain.sv
`timescale 1ns/1ps
module dbg_reg_chain
    import dbg_chain_pkg::*;
#(
    parameter int                RAM_DEPTH = 16,
    parameter int                SEL_W     = 4,
    parameter logic [DATA_W-1:0] ID_VALUE  = 32'h0B57_1D01
) (
    input  logic clk,
    input  logic rst,
    input  logic tck,
    input  logic tms,
    input  logic tdi,
    output logic tdo
);
    tap_state_e        state;
    acc_req_t          req;
    logic              req_tgl, req_sync, ack_tgl, ack_sync;
    logic [DATA_W-1:0] rd_data;

    dbg_tap_fsm u_fsm (.tck(tck), .rst(rst), .tms(tms), .state(state));

    dbg_chain_tck #(.SEL_W(SEL_W)) u_chain (
        .tck(tck), .rst(rst), .tdi(tdi), .state(state),
        .ack_sync(ack_sync), .rd_data(rd_data),
        .tdo(tdo), .req_tgl(req_tgl), .req(req)
    );

    dbg_sync2 u_req_sync (.clk(clk), .rst(rst), .d(req_tgl), .q(req_sync));
    dbg_sync2 u_ack_sync (.clk(tck), .rst(rst), .d(ack_tgl), .q(ack_sync));

    dbg_regfile_stub #(.RAM_DEPTH(RAM_DEPTH), .ID_VALUE(ID_VALUE)) u_bank (
        .clk(clk), .rst(rst), .req_sync(req_sync), .req(req),
        .ack_tgl(ack_tgl), .rd_data(rd_data)
    );
endmodule

// File: tb/dbg_reg_chain_bench.sv
`timescale 1ns/1ps
module dbg_reg_chain_bench;
    localparam logic [31:0] ID  = 32'h0B57_1D01;
    localparam int          DEP = 16;

    logic clk = 1'b0, tck = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b0;
    wire  tdo;

    always #2.5 clk = ~clk;
    always #10  tck = ~tck;

    dbg_reg_chain u_dbg_reg_chain (.clk(clk), .rst(rst), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo));

    int checks = 0, errors = 0;

    typedef struct { logic [39:0] val; string tag; } exp_t;
    exp_t        exp_q[$];
    logic [39:0] act_q[$];
    event        got_act;

    // Reference model of the bank and the chain select
    logic [31:0] m_mem [DEP];
    logic [31:0] m_scratch = 0, m_last = 0;
    int          m_rptr = 0, m_wptr = 0;
    logic [3:0]  m_sel = 4'hF;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares each captured access word with the oldest expectation
    initial forever begin
        @(got_act);
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            exp_t        e;
            logic [39:0] a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            check(e.tag, {24'h0, a}, {24'h0, e.val});
        end
    end

    task automatic tick(logic m, logic d);
        @(negedge tck);
        tms = m;
        tdi = d;
        @(posedge tck);
    endtask

    task automatic shift_bits(int n, logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge tck);
            dout[i] = tdo;
            tdi = din[i];
            tms = (i == n - 1);
            @(posedge tck);
        end
        tick(1'b1, 1'b0);                           // Exit1 -> Update
        for (int k = 0; k < 8; k++) tick(1'b0, 1'b0); // settle in Idle
    endtask

    task automatic dr_scan(int n, logic [63:0] din, output logic [63:0] dout);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        shift_bits(n, din, dout);
    endtask

    task automatic ir_scan(logic [3:0] code, output logic [3:0] cap);
        logic [63:0] o;
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        shift_bits(4, {60'h0, code}, o);
        cap = o[3:0];
    endtask

    function automatic logic [31:0] m_read(logic [6:0] a);
        logic [31:0] v;
        case (a)
            7'd0: v = ID;
            7'd1: v = DEP;
            7'd2: v = m_scratch;
            7'd4: begin v = m_mem[m_rptr]; m_rptr = (m_rptr + 1) % DEP; end
            7'd5: v = m_rptr;
            7'd6: v = m_wptr;
            default: v = 0;
        endcase
        return v;
    endfunction

    task automatic m_write(logic [6:0] a, logic [31:0] d);
        case (a)
            7'd2: m_scratch = d;
            7'd4: begin m_mem[m_wptr] = d; m_wptr = (m_wptr + 1) % DEP; end
            7'd5: m_rptr = d % DEP;
            7'd6: m_wptr = d % DEP;
            default: ;
        endcase
    endtask

    // Driver: one access scan; tag names the requirement its capture verifies
    task automatic acc(logic wr, logic [6:0] a, logic [31:0] d, string tag);
        exp_t        e;
        logic [63:0] o;
        e.val = {8'h00, (m_sel == 4'h0) ? m_last : 32'h0};
        e.tag = tag;
        exp_q.push_back(e);
        dr_scan(40, {24'h0, wr, a, d}, o);
        act_q.push_back(o[39:0]);
        -> got_act;
        if (m_sel == 4'h0) begin
            if (wr) m_write(a, d);
            else    m_last = m_read(a);
        end
    endtask

    task automatic select_chain(logic [3:0] n, logic [3:0] exp_cap, string tag);
        logic [3:0]  c;
        logic [63:0] o;
        ir_scan(4'h2, c);
        dr_scan(4, {60'h0, n}, o);
        check(tag, o, {60'h0, exp_cap});
        m_sel = n;
        ir_scan(4'hC, c);
    endtask

    task automatic bypass_check(string tag);
        logic [63:0] o;
        dr_scan(2, 64'h1, o);
        check(tag, o, 64'h2);
    endtask

    initial begin
        logic [3:0] cap;
        repeat (4) @(posedge tck);
        @(negedge tck) rst = 1'b0;
        tick(1'b0, 1'b0);
        @(negedge tck);
        check("R1 tdo idle", {63'h0, tdo}, 64'h0);
        bypass_check("R1 bypass after reset");
        ir_scan(4'hC, cap);
        check("R1 ir capture", {60'h0, cap}, 64'h1);

        // Access before chain 0 is selected
        acc(1'b1, 7'd2, 32'h0000_1234, "R8 unselected capture");
        select_chain(4'h0, 4'hF, "R8 chain reset value");
        acc(1'b0, 7'd2, 32'h0, "R8 prior write");
        acc(1'b1, 7'd2, 32'hDEAD_BEEF, "R8 scratch kept");
        acc(1'b0, 7'd2, 32'h0, "R4 write keeps result");
        acc(1'b0, 7'd0, 32'h0, "R3 scratch written");
        acc(1'b0, 7'd1, 32'h0, "R4 id result");
        acc(1'b1, 7'd4, 32'h11, "R7 depth");
        acc(1'b1, 7'd4, 32'h22, "R4 ram write");
        acc(1'b1, 7'd4, 32'h33, "R4 ram write");
        acc(1'b1, 7'd5, 32'h0, "R4 ram write");
        acc(1'b0, 7'd4, 32'h0, "R4 rptr write");
        acc(1'b0, 7'd4, 32'h0, "R5 first entry");
        acc(1'b0, 7'd0, 32'h0, "R5 second entry");
        acc(1'b0, 7'd5, 32'h0, "R5 id read");
        acc(1'b0, 7'd6, 32'h0, "R5 rptr advanced");
        acc(1'b1, 7'd6, 32'd15, "R6 wptr after writes");
        acc(1'b1, 7'd4, 32'hAA, "R4 wptr write");
        acc(1'b1, 7'd4, 32'hBB, "R4 ram write");
        acc(1'b0, 7'd6, 32'h0, "R4 ram write");
        acc(1'b1, 7'd5, 32'd15, "R6 wptr wrapped");
        acc(1'b0, 7'd4, 32'h0, "R4 rptr write");
        acc(1'b0, 7'd4, 32'h0, "R6 last entry");
        acc(1'b0, 7'd0, 32'h0, "R6 wrapped entry");
        acc(1'b1, 7'd0, 32'h0, "R4 id");
        acc(1'b0, 7'd0, 32'h0, "R4 id write");
        acc(1'b1, 7'd3, 32'h55, "R7 id unchanged");
        acc(1'b0, 7'd3, 32'h0, "R4 hole write");
        acc(1'b0, 7'h7F, 32'h0, "R7 hole reads zero");
        acc(1'b1, 7'h40, 32'h1, "R7 top reads zero");
        acc(1'b0, 7'd2, 32'h0, "R4 high write");
        acc(1'b0, 7'd0, 32'h0, "R7 scratch after unmapped");

        // Unknown instruction
        ir_scan(4'h5, cap);
        bypass_check("R9 code 5 bypass");

        // Test-Logic-Reset by five TMS-high cycles
        for (int k = 0; k < 5; k++) tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        m_sel = 4'hF;
        bypass_check("R10 bypass after tlr");
        ir_scan(4'hC, cap);
        acc(1'b0, 7'd0, 32'h0, "R10 chain deselected");
        acc(1'b1, 7'd2, 32'h0, "R10 chain deselected");
        select_chain(4'h0, 4'hF, "R10 chain reset");
        acc(1'b0, 7'd2, 32'h0, "R10 result retained");
        acc(1'b0, 7'd0, 32'h0, "R10 scratch intact");
        acc(1'b0, 7'd0, 32'h0, "R2 id via chain");

        #100;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule